// File: doc/BRIEF.md
# Linear Chirp Tone Generator

This block produces a digital linear frequency sweep, one signed sample for each pulse of a sample-enable strobe. Two 32-bit words set the sweep: a start frequency and a per-sample frequency step. A frequency accumulator adds the step to the instantaneous frequency on every sample. A phase accumulator advances by that frequency. The upper phase bits address a quarter-wave sine table, which yields a 16-bit signed sample.

A sweep period is a programmable number of samples, normally one second at the running sample rate (for example 48000). When a period ends, the frequency returns to the start value and the sweep repeats. Software loads each 32-bit word one byte at a time into shadow storage. The shadow values take effect only when the next period begins, so a sweep never runs with a partly written word. The finished sample is sent to every output lane that is enabled for this generator.

Top module: `chirp_gen`

## Requirements
- R1: After a synchronous reset, `sample_out`, `sample_valid` and every lane of `chan_out` read 0. Both shadow words, the phase and the frequency are 0, and the next strobe begins a new sweep period.
- R2: The first strobe of each sweep period loads the start word and the step word from shadow storage. That sample's instantaneous frequency equals the shadow start word.
- R3: On every later strobe in the period, the instantaneous frequency is the previous one plus the step, modulo 2^32. On every strobe, the phase advances by the instantaneous frequency, modulo 2^32.
- R4: A period lasts `period_len` strobes. After the last one, the next strobe restarts at the start frequency. If `period_len` is 0 or 1, every strobe restarts the sweep.
- R5: A step of zero gives a steady tone at the start frequency. For example, with a start word of 0x40000000 the outputs repeat as 101, 32767, -101, -32767.
- R6: A write with `wr_en` high stores `wr_data` into one byte of a shadow word. `wr_sel` = 0 selects the start word and 1 selects the step word. `wr_byte` = 0 writes bits 31:24, and `wr_byte` = 3 writes bits 7:0. The other bytes do not change. A written value has no effect until the next period begins.
- R7: On a strobe, `sample_out` is registered from the phase held before that strobe's advance, and it holds its value between strobes. Phase bits 31:30 give the quadrant q and bits 29:22 give the index a. The table index m is a for even q and 255-a for odd q. The magnitude is round(32767*sin(pi*(2m+1)/1024)), negated when q >= 2. `sample_valid` is high for exactly the cycle after each strobe.
- R8: While `sample_en` is low, the phase, the frequency and the period count do not change.
- R9: Lane c of `chan_out` (bits 16c+15:16c) equals `sample_out` when `chan_en[c]` is 1, and reads 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_en | input | 1 | Sample strobe; one sample is produced per high cycle |
| period_len | input | 32 | Number of samples in one sweep period |
| wr_en | input | 1 | Byte write strobe |
| wr_sel | input | 1 | Word select: 0 = start frequency, 1 = frequency step |
| wr_byte | input | 2 | Byte select: 0 = bits 31:24, 3 = bits 7:0 |
| wr_data | input | 8 | Byte value to write |
| chan_en | input | 4 | Per-lane enable |
| sample_out | output | 16 | Signed sine sample |
| sample_valid | output | 1 | High for one cycle after each strobe |
| chan_out | output | 64 | Four 16-bit lanes carrying the gated sample |

## Verification
A zero step with a quarter-cycle start frequency visits exactly the four quadrant boundary codes. This separates the byte ordering, the quadrant mirroring and the sign handling from the accumulation logic. A three-sample period whose step equals its start frequency makes each restart visible as a repeat of a known six-value pattern. A zero-length period with a large step shows whether every strobe really restarts the sweep. Long runs with irregular strobes, mid-sweep shadow writes, changing lane enables and a 48000-sample period are compared every clock against a behavioural model. These runs separate the deferred loading, the idle holding and the wrap at the end of the period from one another.

// File: rtl/chirp_pkg.sv
package chirp_pkg;

    localparam int ACC_W  = 32;
    localparam int OUT_W  = 16;
    localparam int LUT_AW = 8;

    // Quarter-wave magnitude for table slot idx, sampled at the slot centre.
    function automatic int quarter_entry(int idx, int aw, int ow);
        real ang;
        real amp;
        ang = 3.14159265358979 * real'(2 * idx + 1) / real'(1 << (aw + 2));
        amp = real'((1 << (ow - 1)) - 1);
        return $rtoi(amp * $sin(ang) + 0.5);
    endfunction

endpackage

// File: rtl/chirp_cfg.sv
module chirp_cfg #(
    parameter int ACC_W = chirp_pkg::ACC_W,
    localparam int NB  = ACC_W / 8,
    localparam int BSW = $clog2(NB)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [BSW-1:0]   wr_byte,
    input  logic [7:0]       wr_data,
    output logic [ACC_W-1:0] start_sh,
    output logic [ACC_W-1:0] incr_sh
);

    typedef struct packed {
        logic [ACC_W-1:0] start;
        logic [ACC_W-1:0] incr;
    } shadow_t;

    shadow_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (wr_en) begin
            for (int b = 0; b < NB; b++) begin
                if (wr_byte == BSW'(b)) begin
                    if (wr_sel) sh_d.incr[(NB-1-b)*8 +: 8]  = wr_data;
                    else        sh_d.start[(NB-1-b)*8 +: 8] = wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= sh_d;
    end

    assign start_sh = sh_q.start;
    assign incr_sh  = sh_q.incr;

    AST_START_BYTE_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en && !wr_sel |=> 8'(start_sh >> (8 * (NB - 1 - int'($past(wr_byte))))) == $past(wr_data)); // R6
    AST_INCR_BYTE_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_sel |=> 8'(incr_sh >> (8 * (NB - 1 - int'($past(wr_byte))))) == $past(wr_data)); // R6

endmodule

// File: rtl/chirp_core.sv
module chirp_core #(
    parameter int ACC_W = chirp_pkg::ACC_W,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sample_en,
    input  logic [CNT_W-1:0] period_len,
    input  logic [ACC_W-1:0] start_sh,
    input  logic [ACC_W-1:0] incr_sh,
    output logic [ACC_W-1:0] phase
);

    typedef struct packed {
        logic [ACC_W-1:0] phase;
        logic [ACC_W-1:0] freq;
        logic [ACC_W-1:0] incr;
        logic [CNT_W-1:0] cnt;
    } acc_t;

    acc_t s_d, s_q;
    logic first_d;
    logic [CNT_W:0] cnt_nx;

    always_comb begin
        s_d     = s_q;
        first_d = (s_q.cnt == '0);
        cnt_nx  = {1'b0, s_q.cnt} + 1'b1;
        if (sample_en) begin
            if (first_d) begin
                s_d.freq = start_sh;
                s_d.incr = incr_sh;
            end else begin
                s_d.freq = s_q.freq + s_q.incr;
            end
            s_d.phase = s_q.phase + s_d.freq;
            s_d.cnt   = (cnt_nx >= {1'b0, period_len}) ? '0 : cnt_nx[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign phase = s_q.phase;

    logic [ACC_W-1:0] freq_q, incr_q;
    logic [CNT_W-1:0] cnt_q;
    assign freq_q = s_q.freq;
    assign incr_q = s_q.incr;
    assign cnt_q  = s_q.cnt;

    AST_FREQ_RESTART: assert property (@(posedge clk) disable iff (rst)
        sample_en && cnt_q == '0 |=> freq_q == $past(start_sh)); // R2
    AST_FREQ_STEP: assert property (@(posedge clk) disable iff (rst)
        sample_en && cnt_q != '0 |=> freq_q == $past(freq_q) + $past(incr_q)); // R3
    AST_PERIOD_WRAP: assert property (@(posedge clk) disable iff (rst)
        sample_en && ({1'b0, cnt_q} + 1'b1 >= {1'b0, period_len}) |=> cnt_q == '0); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !sample_en |=> $stable(phase) && $stable(freq_q) && $stable(cnt_q)); // R8

endmodule

// File: rtl/chirp_sine.sv
module chirp_sine #(
    parameter int LUT_AW = chirp_pkg::LUT_AW,
    parameter int OUT_W  = chirp_pkg::OUT_W,
    localparam int DEPTH = 1 << LUT_AW
) (
    input  logic [LUT_AW+1:0] ph_top,
    output logic [OUT_W-1:0]  value
);

    logic [OUT_W-1:0]  rom [DEPTH];
    logic [1:0]        quad;
    logic [LUT_AW-1:0] ang;
    logic [LUT_AW-1:0] idx;
    logic [OUT_W-1:0]  mag;

    for (genvar i = 0; i < DEPTH; i++) begin : g_rom
        assign rom[i] = OUT_W'(chirp_pkg::quarter_entry(i, LUT_AW, OUT_W));
    end

    always_comb begin
        quad  = ph_top[LUT_AW+1:LUT_AW];
        ang   = ph_top[LUT_AW-1:0];
        idx   = quad[0] ? ~ang : ang;
        mag   = rom[idx];
        value = quad[1] ? (~mag + OUT_W'(1)) : mag;
    end

endmodule

// File: rtl/chirp_gen.sv
module chirp_gen #(
    parameter int NCH    = 4,
    parameter int ACC_W  = chirp_pkg::ACC_W,
    parameter int OUT_W  = chirp_pkg::OUT_W,
    parameter int LUT_AW = chirp_pkg::LUT_AW,
    parameter int CNT_W  = 32,
    localparam int BSW   = $clog2(ACC_W / 8)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sample_en,
    input  logic [CNT_W-1:0]     period_len,
    input  logic                 wr_en,
    input  logic                 wr_sel,
    input  logic [BSW-1:0]       wr_byte,
    input  logic [7:0]           wr_data,
    input  logic [NCH-1:0]       chan_en,
    output logic [OUT_W-1:0]     sample_out,
    output logic                 sample_valid,
    output logic [NCH*OUT_W-1:0] chan_out
);

    logic [ACC_W-1:0] start_sh, incr_sh, phase;
    logic [OUT_W-1:0] lut_val;

    chirp_cfg #(.ACC_W(ACC_W)) u_cfg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_byte(wr_byte), .wr_data(wr_data),
        .start_sh(start_sh), .incr_sh(incr_sh)
    );

    chirp_core #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_core (
        .clk(clk), .rst(rst), .sample_en(sample_en), .period_len(period_len),
        .start_sh(start_sh), .incr_sh(incr_sh), .phase(phase)
    );

    chirp_sine #(.LUT_AW(LUT_AW), .OUT_W(OUT_W)) u_sine (
        .ph_top(phase[ACC_W-1 -: LUT_AW+2]), .value(lut_val)
    );

    typedef struct packed {
        logic [OUT_W-1:0] smp;
        logic             vld;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d     = o_q;
        o_d.vld = sample_en;
        if (sample_en) o_d.smp = lut_val;
    end

    always_ff @(posedge clk) begin
        if (rst) o_q <= '0;
        else     o_q <= o_d;
    end

    assign sample_out   = o_q.smp;
    assign sample_valid = o_q.vld;

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        assign chan_out[c*OUT_W +: OUT_W] = chan_en[c] ? o_q.smp : '0;
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        sample_en |=> sample_valid); // R7
    AST_VALID_QUIET: assert property (@(posedge clk) disable iff (rst)
        !sample_en |=> !sample_valid && $stable(sample_out)); // R7

endmodule

// File: tb/sim_chirp_gen.sv
`timescale 1ns/100ps
module sim_chirp_gen;

    localparam real PI = 3.14159265358979;
    localparam longint M32 = 64'hFFFF_FFFF;

    logic        clk = 0;
    logic        rst = 1;
    logic        sample_en = 0;
    logic [31:0] period_len = 32'd1000;
    logic        wr_en = 0;
    logic        wr_sel = 0;
    logic [1:0]  wr_byte = 0;
    logic [7:0]  wr_data = 0;
    logic [3:0]  chan_en = 4'hF;
    logic [15:0] sample_out;
    logic        sample_valid;
    logic [63:0] chan_out;

    int n_chk = 0;
    int n_bad = 0;
    bit armed = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    chirp_gen u0 (
        .clk(clk), .rst(rst), .sample_en(sample_en), .period_len(period_len),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_byte(wr_byte), .wr_data(wr_data),
        .chan_en(chan_en), .sample_out(sample_out), .sample_valid(sample_valid),
        .chan_out(chan_out)
    );

    task automatic chk(string tag, longint act, longint exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d @%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int sine_ref(longint ph);
        int q, a, m, v;
        q = int'((ph >> 30) & 3);
        a = int'((ph >> 22) & 255);
        m = (q % 2 == 1) ? 255 - a : a;
        v = $rtoi(32767.0 * $sin(PI * real'(2 * m + 1) / 1024.0) + 0.5);
        return (q >= 2) ? -v : v;
    endfunction

    // Behavioural reference model
    longint m_phase, m_freq, m_inc, m_cnt, m_sh_start, m_sh_inc;
    int     m_out;
    bit     m_valid;

    always @(posedge clk) begin
        armed <= 1;
        if (rst) begin
            m_phase = 0; m_freq = 0; m_inc = 0; m_cnt = 0;
            m_sh_start = 0; m_sh_inc = 0; m_out = 0; m_valid = 0;
        end else begin
            if (sample_en) begin
                m_out = sine_ref(m_phase);
                m_valid = 1;
                if (m_cnt == 0) begin
                    m_freq = m_sh_start;
                    m_inc  = m_sh_inc;
                end else begin
                    m_freq = (m_freq + m_inc) & M32;
                end
                m_phase = (m_phase + m_freq) & M32;
                m_cnt = m_cnt + 1;
                if (m_cnt >= longint'(period_len)) m_cnt = 0;
            end else begin
                m_valid = 0;
            end
            if (wr_en) begin
                longint sh;
                sh = longint'(8 * (3 - int'(wr_byte)));
                if (wr_sel) m_sh_inc   = (m_sh_inc   & ~(longint'(255) << sh)) | (longint'(wr_data) << sh);
                else        m_sh_start = (m_sh_start & ~(longint'(255) << sh)) | (longint'(wr_data) << sh);
            end
        end
    end

    // Cycle-by-cycle comparison against the model (R2/R3/R6/R7/R8/R9)
    always @(negedge clk) begin
        if (armed && !done) begin
            chk("R2/R3/R6/R7 model sample", longint'($signed(sample_out)), longint'(m_out));
            chk("R7 model valid", longint'(sample_valid), longint'(m_valid));
            for (int c = 0; c < 4; c++)
                chk("R9 model lane", longint'($signed(chan_out[c*16 +: 16])),
                    chan_en[c] ? longint'(m_out) : 0);
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input bit sel, input int b, input logic [7:0] d);
        wr_en = 1; wr_sel = sel; wr_byte = 2'(b); wr_data = d;
        tick();
        wr_en = 0;
    endtask

    task automatic load(input bit sel, input logic [31:0] v);
        for (int b = 0; b < 4; b++) wr(sel, b, v[31 - 8*b -: 8]);
    endtask

    task automatic strobe(output int s);
        sample_en = 1;
        tick();
        sample_en = 0;
        s = int'($signed(sample_out));
    endtask

    task automatic do_reset();
        rst = 1;
        tick(); tick();
        rst = 0;
    endtask

    initial begin
        #(5.0 * 300000);
        $display("FAIL watchdog expired actual=0 expected=1");
        n_chk++; n_bad++;
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int s;
        int exp4[4];
        int exp6[6];
        logic [15:0] held;
        exp4 = '{101, 32767, -101, -32767};
        exp6 = '{101, 32767, -32767, -101, -32767, 32767};

        tick(); tick();
        rst = 0;
        do_reset();
        // R1: reset state
        chk("R1 sample_out", longint'(sample_out), 0);
        chk("R1 sample_valid", longint'(sample_valid), 0);
        chk("R1 chan_out", longint'(chan_out), 0);

        // R5/R6/R7: steady tone, start word written byte by byte (byte 0 = bits 31:24)
        period_len = 32'd65536;
        load(0, 32'h4000_0000);
        load(1, 32'h0000_0000);
        for (int i = 0; i < 8; i++) begin
            strobe(s);
            chk("R5 steady tone", s, exp4[i % 4]);
        end

        // R2/R3/R4: period 3, step equal to start frequency
        do_reset();
        period_len = 32'd3;
        load(0, 32'h4000_0000);
        load(1, 32'h4000_0000);
        for (int i = 0; i < 6; i++) begin
            strobe(s);
            chk("R4 period restart", s, exp6[i]);
        end

        // R4: zero-length period restarts every strobe despite a large step
        do_reset();
        period_len = 32'd0;
        load(0, 32'h4000_0000);
        load(1, 32'h1234_5678);
        for (int i = 0; i < 8; i++) begin
            strobe(s);
            chk("R4 zero period", s, exp4[i % 4]);
        end

        // R8: outputs hold across idle cycles
        held = sample_out;
        for (int i = 0; i < 5; i++) begin
            tick();
            chk("R8 idle hold", longint'(sample_out), longint'(held));
        end

        // R9: lane gating
        chan_en = 4'b0101;
        #0.5;
        chk("R9 lane0 on", longint'(chan_out[15:0]), longint'(sample_out));
        chk("R9 lane1 off", longint'(chan_out[31:16]), 0);
        chan_en = 4'hF;

        // R6: shadow writes mid-sweep take effect only at the next period start
        do_reset();
        period_len = 32'd5;
        load(0, 32'h0300_0000);
        load(1, 32'h0010_0000);
        for (int i = 0; i < 12; i++) begin
            strobe(s);
            if (i == 2) load(0, 32'h2000_0000);
            if (i == 6) wr(1, 1, 8'h40);
        end

        // R3/R8/R9: irregular strobes, random writes and lane enables
        period_len = 32'd37;
        for (int i = 0; i < 4000; i++) begin
            sample_en = ($urandom % 3) != 0;
            wr_en     = ($urandom % 17) == 0;
            wr_sel    = 1'($urandom);
            wr_byte   = 2'($urandom);
            wr_data   = 8'($urandom);
            if ((i % 50) == 0) chan_en = 4'($urandom);
            tick();
        end
        sample_en = 0; wr_en = 0;

        // R4: one-second period at 48 kHz
        do_reset();
        period_len = 32'd48000;
        load(0, 32'h0001_0000);
        load(1, 32'h0000_0123);
        sample_en = 1;
        for (int i = 0; i < 48100; i++) tick();
        sample_en = 0;
        tick();

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule